// File: doc/BRIEF.md
# Serial Configuration and Pixel Readout Port

This block is the digital face of a line-sensor digitizer. A host talks to it over one data line whose direction follows a mode input: with mode low the line carries an 8-bit control word into the block, and a load strobe then commits that word's six payload bits to the front-end register named by its two leading address bits. One register picks the analog source that feeds the converter. The other holds the amplifier gain code.

With mode high the line carries conversion results out, most significant bit first. Each result is captured when the converter reports it. It then moves into a holding register and into an output shifter on successive falling edges of the pixel sample strobe. A pixel therefore reaches the line two sample periods after it was taken.

All host inputs are asynchronous. Each one passes through a two-stage synchronizer and an edge detector in the system clock domain. The serial clock must run at no more than a quarter of the system clock rate. Every action described below occurs three system clock edges after the input edge that causes it.

Top module: `ccd_serial_port`

## Requirements
- R1: `data_oe_o` is 0 while mode is low and 1 while mode is high. While the driver is off, `data_out_o` is 0.
- R2: In write mode the block takes one bit per serial clock rising edge, the first bit received being the most significant bit of the word. A rising edge of load commits the word only once at least eight bits have arrived since the previous commit or since the last return to write mode.
- R3: Address bits 10 (first bit 1, second bit 0) write the six payload bits, received from D5 down to D0, to `gain_code_o`. Code n stands for a gain of -(2 + n/8), so code 0 is -2 and code 63 is -9.875.
- R4: Address bits 01 write the source select `mux_sel_o`. Payload D5:D4 = 00 selects the sensor path (0), 01 selects auxiliary input 1 (1), and 10 selects auxiliary input 2 (2). D5:D4 = 11 leaves the select unchanged, and `mux_sel_o` never reads 3.
- R5: Address bits 00 and 11 change neither register.
- R6: A load rising edge that arrives after fewer than eight bits changes neither register, and it restarts the bit count.
- R7: After reset, `mux_sel_o` = 0, `gain_code_o` = 0, `data_oe_o` = 0 and `data_out_o` = 0.
- R8: In read mode a falling edge of the sample strobe places D7 of the output word on `data_out_o`. Each later serial clock rise presents the next lower bit.
- R9: A result reported after sample-strobe fall k appears at the pin after fall k+2. The words shown after the first two falls following reset are 0.
- R10: If a sample-strobe fall and a serial clock rise are detected in the same cycle, the new word is loaded and the shift is dropped, so D7 of the new word appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = control write, 1 = result readout (asynchronous) |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| load_i | input | 1 | Commit strobe for a control word (asynchronous) |
| vsamp_i | input | 1 | Pixel sample strobe; its falling edge advances the readout (asynchronous) |
| data_in_i | input | 1 | Receive side of the data line |
| data_out_o | output | 1 | Transmit side of the data line |
| data_oe_o | output | 1 | Driver enable for the data line |
| res_i | input | 8 | Converter result |
| res_valid_i | input | 1 | One-cycle strobe marking `res_i` valid |
| mux_sel_o | output | 2 | Analog source select |
| gain_code_o | output | 6 | Amplifier gain code |

## Verification
Two events can be detected in the same system cycle: a sample-strobe fall, which reloads the output shifter, and a serial clock rise, which shifts it. The bench reaches this case in the middle of a readout. It lowers the sample strobe and raises the serial clock on the same clock edge, so both pass through identical synchronizer depth and land together. The pin must then show D7 of the pixel expected for that fall, not the next bit of the old word, and the later rises must continue the new word bit by bit.

// File: rtl/ccdp_pkg.sv
// Shared encodings for the serial configuration / readout port.
// Assumes: address is the first two bits received, in arrival order.
package ccdp_pkg;
    typedef enum logic [1:0] {
        ADR_IDLE0 = 2'b00,
        ADR_SRC   = 2'b01,
        ADR_GAIN  = 2'b10,
        ADR_IDLE1 = 2'b11
    } addr_e;

    typedef enum logic [1:0] {
        SRC_SENSOR = 2'b00,
        SRC_AUX1   = 2'b01,
        SRC_AUX2   = 2'b10,
        SRC_KEEP   = 2'b11
    } src_e;

    // positions of the host inputs in the synchronizer vector
    localparam int IDX_SCLK  = 0;
    localparam int IDX_LOAD  = 1;
    localparam int IDX_MODE  = 2;
    localparam int IDX_VSAMP = 3;
    localparam int IDX_DIN   = 4;
    localparam int N_SYNC    = 5;
endpackage

// File: rtl/ccdp_sync.sv
// Two-stage synchronizer with rise/fall detection for each of N inputs.
// Assumes: inputs stay stable for at least two system clocks per level.
module ccdp_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic s1, s2, s3;
            // resample the input and keep one older copy for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                    s3 <= 1'b0;
                end else begin
                    s1 <= async_i[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign lvl_o[g]  = s2;
            assign rise_o[g] = s2 & ~s3;
            assign fall_o[g] = ~s2 & s3;
        end
    endgenerate
endmodule

// File: rtl/ccdp_cfg_write.sv
// Receives a control word bit by bit and commits its payload to the
// source-select or gain register on a commit strobe.
// Assumes: strobes are single-cycle pulses from the synchronizer.
module ccdp_cfg_write
    import ccdp_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int PAY_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             commit_stb,
    output logic [1:0]       src_sel,
    output logic [PAY_W-1:0] gain_code
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        src_q;
    logic [PAY_W-1:0]  gain_q;
    addr_e             adr;
    logic [1:0]        src_pay;
    logic              take;

    assign adr     = addr_e'(sh_q[WORD_W-1 -: 2]);
    assign src_pay = sh_q[PAY_W-1 -: 2];
    assign take    = commit_stb && (cnt_q == FULL);

    // collect incoming bits and count them; commit or leaving write mode restarts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (!wr_en || commit_stb) begin
            cnt_q <= '0;
        end else if (bit_stb) begin
            sh_q  <= {sh_q[WORD_W-2:0], bit_val};
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // route a complete word's payload to the register its address names
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_SENSOR;
            gain_q <= '0;
        end else if (take) begin
            if (adr == ADR_SRC && src_pay != SRC_KEEP) src_q <= src_pay;
            if (adr == ADR_GAIN) gain_q <= sh_q[PAY_W-1:0];
        end
    end

    assign src_sel   = src_q;
    assign gain_code = gain_q;

    assert_src_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_q != SRC_KEEP);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    assert_short_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb && cnt_q != FULL) |=> ($stable(src_q) && $stable(gain_q)));
    assert_idle_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (adr == ADR_IDLE0 || adr == ADR_IDLE1)) |=> ($stable(src_q) && $stable(gain_q)));
endmodule

// File: rtl/ccdp_readout.sv
// Result pipeline: capture register, holding register, output shifter.
// Assumes: at most one result is reported per sample period.
module ccdp_readout #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_i,
    input  logic             res_valid_i,
    input  logic             frame_stb,
    input  logic             shift_stb,
    output logic             bit_o
);
    logic [RES_W-1:0] cap_q, hold_q, sh_q;

    // capture the converter result whenever it is reported
    always_ff @(posedge clk) begin
        if (!rst_n)           cap_q <= '0;
        else if (res_valid_i) cap_q <= res_i;
    end

    // advance the two-stage pipeline on each sample strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (frame_stb) hold_q <= cap_q;
    end

    // load the shifter on a frame strobe; otherwise shift out MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)         sh_q <= '0;
        else if (frame_stb) sh_q <= hold_q;
        else if (shift_stb) sh_q <= {sh_q[RES_W-2:0], 1'b0};
    end

    assign bit_o = sh_q[RES_W-1];

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> sh_q == $past(hold_q));
    assert_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && !frame_stb) |=> sh_q == {$past(sh_q[RES_W-2:0]), 1'b0});
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> hold_q == $past(cap_q));
endmodule

// File: rtl/ccd_serial_port.sv
// Top: bidirectional serial port for configuration writes and pixel readout.
// Assumes: serial clock at most a quarter of clk; one data line split into
// receive, transmit and driver-enable signals for an external pad.
module ccd_serial_port
    import ccdp_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int PAY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             sclk_i,
    input  logic             load_i,
    input  logic             vsamp_i,
    input  logic             data_in_i,
    output logic             data_out_o,
    output logic             data_oe_o,
    input  logic [RES_W-1:0] res_i,
    input  logic             res_valid_i,
    output logic [1:0]       mux_sel_o,
    output logic [PAY_W-1:0] gain_code_o
);
    logic [N_SYNC-1:0] raw, lvl, rise, fall;
    logic rd_mode, tx_bit;

    assign raw[IDX_SCLK]  = sclk_i;
    assign raw[IDX_LOAD]  = load_i;
    assign raw[IDX_MODE]  = mode_i;
    assign raw[IDX_VSAMP] = vsamp_i;
    assign raw[IDX_DIN]   = data_in_i;

    ccdp_sync #(.N(N_SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign rd_mode = lvl[IDX_MODE];

    ccdp_cfg_write #(.WORD_W(2 + PAY_W), .PAY_W(PAY_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(!rd_mode),
        .bit_stb(rise[IDX_SCLK] && !rd_mode),
        .bit_val(lvl[IDX_DIN]),
        .commit_stb(rise[IDX_LOAD] && !rd_mode),
        .src_sel(mux_sel_o),
        .gain_code(gain_code_o)
    );

    ccdp_readout #(.RES_W(RES_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .res_i(res_i), .res_valid_i(res_valid_i),
        .frame_stb(fall[IDX_VSAMP]),
        .shift_stb(rise[IDX_SCLK] && rd_mode),
        .bit_o(tx_bit)
    );

    assign data_oe_o  = rd_mode;
    assign data_out_o = rd_mode & tx_bit;

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> !data_out_o);
    assert_cfg_hold_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_mode) && rd_mode) |-> ($stable(mux_sel_o) && $stable(gain_code_o)));
endmodule

// File: tb/tb_ccd_serial_port.sv
module tb_ccd_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0, sclk_i = 1'b0, load_i = 1'b0, vsamp_i = 1'b0, data_in_i = 1'b0;
    logic [7:0] res_i = '0;
    logic res_valid_i = 1'b0;
    logic data_out_o, data_oe_o;
    logic [1:0] mux_sel_o;
    logic [5:0] gain_code_o;

    int n_chk = 0, n_err = 0;
    int exp_mux = 0, exp_gain = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccd_serial_port dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sclk_i(sclk_i), .load_i(load_i),
        .vsamp_i(vsamp_i), .data_in_i(data_in_i), .data_out_o(data_out_o),
        .data_oe_o(data_oe_o), .res_i(res_i), .res_valid_i(res_valid_i),
        .mux_sel_o(mux_sel_o), .gain_code_o(gain_code_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] w, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            data_in_i = w[i]; cyc(4);
            sclk_i = 1'b1;    cyc(4);
            sclk_i = 1'b0;
        end
    endtask

    task automatic strobe_load();
        cyc(4); load_i = 1'b1; cyc(4); load_i = 1'b0; cyc(4);
    endtask

    function automatic logic [7:0] pix(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    // expected word at the pin after fall k (R9: two-period latency)
    function automatic logic [7:0] pin_word(input int k);
        return (k < 2) ? 8'h00 : pix(k - 2);
    endfunction

    task automatic report_result(input int k);
        res_i = pix(k); res_valid_i = 1'b1; cyc(1); res_valid_i = 1'b0;
    endtask

    initial begin
        cyc(4); rst_n = 1'b1; cyc(2);
        // R7 reset state
        check("R7 mux", mux_sel_o, 0);
        check("R7 gain", gain_code_o, 0);
        check("R7 oe", data_oe_o, 0);
        check("R7 dout", data_out_o, 0);

        // R3: full sweep of gain codes
        for (int c = 0; c < 64; c++) begin
            send_bits({2'b10, 6'(c)}, 8); strobe_load();
            exp_gain = c;
            check("R3 gain", gain_code_o, exp_gain);
            check("R3 mux untouched", mux_sel_o, exp_mux);
            check("R1 oe low in write", data_oe_o, 0);
        end
        // R4: every source payload, low bits varied
        for (int s = 0; s < 4; s++) begin
            for (int lo = 0; lo < 16; lo += 5) begin
                send_bits({2'b01, 2'(s), 4'(lo)}, 8); strobe_load();
                if (s != 3) exp_mux = s;
                check("R4 mux", mux_sel_o, exp_mux);
                check("R4 gain untouched", gain_code_o, exp_gain);
            end
        end
        // R5: idle addresses with payloads that would change things
        for (int a = 0; a < 4; a += 3) begin
            for (int p = 0; p < 64; p += 9) begin
                send_bits({2'(a), 6'(p)}, 8); strobe_load();
                check("R5 mux", mux_sel_o, exp_mux);
                check("R5 gain", gain_code_o, exp_gain);
            end
        end
        // R6: short words ignored, and the count restarts
        for (int nb = 1; nb < 8; nb++) begin
            send_bits({2'b10, 6'd21}, nb); strobe_load();
            check("R6 short gain", gain_code_o, exp_gain);
            check("R6 short mux", mux_sel_o, exp_mux);
        end
        send_bits({2'b10, 6'd42}, 8); strobe_load(); exp_gain = 42;
        check("R6 count restarted", gain_code_o, exp_gain);
        // R2: nine bits; last eight form the word
        send_bits(8'b1000_0000, 1); send_bits({2'b01, 2'b10, 4'b0}, 8); strobe_load();
        exp_mux = 2;
        check("R2 last eight bits", mux_sel_o, exp_mux);

        // readout
        mode_i = 1'b1; cyc(5);
        check("R1 oe high in read", data_oe_o, 1);
        for (int k = 0; k < 20; k++) begin
            vsamp_i = 1'b1; cyc(4);
            if (k == 10) begin
                // R10: partially shift, then fall and rise together
                sclk_i = 1'b1; cyc(4); sclk_i = 1'b0; cyc(4);
                sclk_i = 1'b1; cyc(4); sclk_i = 1'b0; cyc(4);
                vsamp_i = 1'b0; sclk_i = 1'b1; cyc(5);
                check("R10 load wins", data_out_o, int'(pin_word(k)[7]));
                sclk_i = 1'b0;
            end else begin
                vsamp_i = 1'b0; cyc(5);
                check("R8 D7 after fall", data_out_o, int'(pin_word(k)[7]));
            end
            report_result(k);
            for (int b = 6; b >= 0; b--) begin
                cyc(4); sclk_i = 1'b1; cyc(4);
                check("R9 bit", data_out_o, int'(pin_word(k)[b]));
                sclk_i = 1'b0;
            end
            cyc(4);
        end
        check("R2 cfg held in read mux", mux_sel_o, exp_mux);
        check("R2 cfg held in read gain", gain_code_o, exp_gain);
        mode_i = 1'b0; cyc(5);
        check("R1 oe off again", data_oe_o, 0);
        check("R1 dout quiet", data_out_o, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule